// File: doc/BRIEF.md
# Programmable Window Gate Generator

This block produces a repeating gate waveform made of a counting interval followed by an idle interval. A single configuration byte sets both interval lengths: the upper nibble sets the high interval and the lower nibble sets the low interval. Each nibble value n gives an interval of (16 − n) base ticks. The base tick is an enable strobe taken from a free-running divider. A one-bit select chooses between a fast tap and a slow tap of that divider.

The divider never restarts. As a result, the gate always changes level on a divider tick, and the first high interval after enable may start up to one tick period late. The configuration byte and the select are taken in only while the generator is stopped. Changes made while it runs have no effect. Along with the gate level, the block emits one-cycle pulses on the first cycle of each new gate level. A downstream edge counter or interrupt source can use these pulses directly.

Top module: `gate_window_gen`

## Requirements
- R1: While running, each high interval lasts exactly (2^FIELD_W − nHi) × P clock cycles. Here nHi is bits 7:4 of the latched configuration byte and P is the selected tick period, so nHi = 0 gives 16 ticks and nHi = 15 gives 1 tick.
- R2: While running, each low interval lasts exactly (2^FIELD_W − nLo) × P clock cycles, where nLo is bits 3:0 of the latched byte.
- R3: The gate alternates high, low, high, and so on without gaps. The high interval always comes first after enable.
- R4: The tick period P is 2^TAP_FAST cycles when the latched select is 0, and 2^TAP_SLOW cycles when it is 1. The default taps are 6 and 14.
- R5: After runEn rises, the gate goes high between 1 and P cycles later, always on a divider tick, because the divider is never restarted.
- R6: The configuration byte and the select are captured only in cycles where runEn is low. Changes made while runEn is high do not alter any interval or the tick period.
- R7: When runEn is sampled low, the gate is low in the following cycle and the phase counter clears. A later enable starts again with a full high interval.
- R8: riseOut is high for exactly the first cycle of each high level, and fallOut for exactly the first cycle of each low level that follows a high level. The two are never high together.
- R9: During and after reset, the gate and both pulses are low. The stored configuration byte and select reset to zero, so an enable held through reset runs 16-tick high and low intervals on the fast tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEn | input | 1 | Run enable; low stops the generator and opens the configuration latch |
| periodByte | input | 2*FIELD_W | Interval byte: upper nibble sets the high length, lower nibble the low length |
| tickSel | input | 1 | Tick source select: 0 fast tap, 1 slow tap |
| gateOut | output | 1 | Gate level |
| riseOut | output | 1 | One-cycle pulse on the first high cycle |
| fallOut | output | 1 | One-cycle pulse on the first low cycle after high |

## Verification
The assertions assume that the configuration inputs carry meaning only while runEn is low. They also assume that runEn is a clean synchronous level that is sampled on each clock edge. The stimulus changes periodByte and tickSel only on falling clock edges. It holds runEn low for several cycles before each measured run, so the value captured is the value intended. Any writes made during a run are deliberate, and they exist to probe the ignore rule.

// File: rtl/gate_window_pkg.sv
package gate_window_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_t;

  // Strobes from control to datapath for the phase counter
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic decCnt;
    logic clrCnt;
  } phaseCmd_t;

endpackage

// File: rtl/gate_window_dp.sv
module gate_window_dp
  import gate_window_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int TAP_FAST = 6,
  parameter int TAP_SLOW = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic [2*FIELD_W-1:0] periodByte,
  input  logic                 tickSel,
  input  phaseCmd_t            cmd,
  output logic                 tick,
  output logic                 cntZero,
  output logic [2*FIELD_W-1:0] cfgByte,
  output logic                 cfgSel
);

  localparam int BYTE_W = 2 * FIELD_W;
  localparam int DIV_W  = (TAP_FAST > TAP_SLOW) ? TAP_FAST : TAP_SLOW;
  localparam int NUM_SRC = 2;

  logic [DIV_W-1:0]   divCnt;
  logic [NUM_SRC-1:0] srcTick;
  logic [FIELD_W-1:0] phaseCnt;
  logic [FIELD_W-1:0] nHi;
  logic [FIELD_W-1:0] nLo;

  // Free-running divider, never restarted by enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // Tick strobes: one cycle when the low tap bits are all ones
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    localparam int TAP_W = (gi == 0) ? TAP_FAST : TAP_SLOW;
    assign srcTick[gi] = &divCnt[TAP_W-1:0];
  end

  // Configuration latch open only while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgByte <= '0;
      cfgSel  <= 1'b0;
    end else if (!runEn) begin
      cfgByte <= periodByte;
      cfgSel  <= tickSel;
    end
  end

  assign tick = srcTick[cfgSel];
  assign nHi  = cfgByte[BYTE_W-1:FIELD_W];
  assign nLo  = cfgByte[FIELD_W-1:0];

  // Phase counter holds ticks remaining minus one; load value is 2^W-1-n
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             phaseCnt <= '0;
    else if (cmd.clrCnt)   phaseCnt <= '0;
    else if (cmd.loadHigh) phaseCnt <= ~nHi;
    else if (cmd.loadLow)  phaseCnt <= ~nLo;
    else if (cmd.decCnt)   phaseCnt <= phaseCnt - 1'b1;
  end

  assign cntZero = (phaseCnt == '0);

endmodule

// File: rtl/gate_window_ctrl.sv
module gate_window_ctrl
  import gate_window_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      tick,
  input  logic      cntZero,
  output phaseCmd_t cmd,
  output logic      gateOut,
  output logic      riseOut,
  output logic      fallOut
);

  phase_t phase;
  phase_t phaseNext;

  always_comb begin
    phaseNext = phase;
    cmd       = '0;
    if (!runEn) begin
      phaseNext  = PH_IDLE;
      cmd.clrCnt = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (tick) begin
            phaseNext    = PH_HIGH;
            cmd.loadHigh = 1'b1;
          end
        end
        PH_HIGH: begin
          if (tick) begin
            if (cntZero) begin
              phaseNext   = PH_LOW;
              cmd.loadLow = 1'b1;
            end else begin
              cmd.decCnt = 1'b1;
            end
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (cntZero) begin
              phaseNext    = PH_HIGH;
              cmd.loadHigh = 1'b1;
            end else begin
              cmd.decCnt = 1'b1;
            end
          end
        end
        default: begin
          phaseNext  = PH_IDLE;
          cmd.clrCnt = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      gateOut <= 1'b0;
      riseOut <= 1'b0;
      fallOut <= 1'b0;
    end else begin
      phase   <= phaseNext;
      gateOut <= (phaseNext == PH_HIGH);
      riseOut <= (phaseNext == PH_HIGH) && (phase != PH_HIGH);
      fallOut <= (phase == PH_HIGH) && (phaseNext != PH_HIGH);
    end
  end

endmodule

// File: rtl/gate_window_gen.sv
module gate_window_gen
  import gate_window_pkg::*;
#(
  parameter int FIELD_W  = 4,
  parameter int TAP_FAST = 6,
  parameter int TAP_SLOW = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic [2*FIELD_W-1:0] periodByte,
  input  logic                 tickSel,
  output logic                 gateOut,
  output logic                 riseOut,
  output logic                 fallOut
);

  phaseCmd_t            cmd;
  logic                 tick;
  logic                 cntZero;
  logic [2*FIELD_W-1:0] cfgByte;
  logic                 cfgSel;

  gate_window_dp #(
    .FIELD_W (FIELD_W),
    .TAP_FAST(TAP_FAST),
    .TAP_SLOW(TAP_SLOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .periodByte(periodByte),
    .tickSel   (tickSel),
    .cmd       (cmd),
    .tick      (tick),
    .cntZero   (cntZero),
    .cfgByte   (cfgByte),
    .cfgSel    (cfgSel)
  );

  gate_window_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (runEn),
    .tick   (tick),
    .cntZero(cntZero),
    .cmd    (cmd),
    .gateOut(gateOut),
    .riseOut(riseOut),
    .fallOut(fallOut)
  );

endmodule

// File: rtl/gate_window_chk.sv
module gate_window_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              runEn,
  input logic              tick,
  input logic [BYTE_W-1:0] cfgByte,
  input logic              cfgSel,
  input logic              gateOut,
  input logic              riseOut,
  input logic              fallOut
);

  assert_rise_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> riseOut);
  assert_fall_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOut) |-> fallOut);
  assert_rise_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    riseOut |-> (gateOut && !fallOut));
  assert_fall_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    fallOut |-> !gateOut);
  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !gateOut);
  assert_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOut) |-> $past(tick && runEn));
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && $past(runEn)) |-> ($stable(cfgByte) && $stable(cfgSel)));

endmodule

bind gate_window_gen gate_window_chk #(.BYTE_W(2*FIELD_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .runEn  (runEn),
  .tick   (tick),
  .cfgByte(cfgByte),
  .cfgSel (cfgSel),
  .gateOut(gateOut),
  .riseOut(riseOut),
  .fallOut(fallOut)
);

// File: tb/gate_window_gen_tb.sv
`timescale 1ns/1ps
module gate_window_gen_tb;

  localparam int FW = 4;
  localparam int TF = 1;
  localparam int TS = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         runEn = 1'b0;
  logic [7:0]   periodByte = '0;
  logic         tickSel = 1'b0;
  logic         gateOut, riseOut, fallOut;

  int compared = 0;
  int mismatched = 0;
  logic prevGate = 1'b0;
  logic monOn = 1'b0;

  always #2.5 clk = ~clk;

  gate_window_gen #(.FIELD_W(FW), .TAP_FAST(TF), .TAP_SLOW(TS)) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .periodByte(periodByte),
    .tickSel(tickSel), .gateOut(gateOut), .riseOut(riseOut), .fallOut(fallOut)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    compared++;
    if (act < lo || act > hi) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d..%0d at %0t", req, act, lo, hi, $time);
    end
  endtask

  // R8 pulse monitor, sampled on falling edges
  always @(negedge clk) begin
    if (monOn) begin
      check("R8 rise", int'(riseOut), int'(gateOut && !prevGate));
      check("R8 fall", int'(fallOut), int'(!gateOut && prevGate));
    end
    prevGate <= gateOut;
  end

  function automatic int periodOf(input logic s);
    return s ? (1 << TS) : (1 << TF);
  endfunction

  task automatic waitLevel(input logic lvl, output int n);
    n = 0;
    while (gateOut != lvl && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic countLevel(input logic lvl, output int n);
    n = 0;
    while (gateOut == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Full run: delay, high, low (with writes while running), high again
  task automatic runOne(input logic [7:0] b, input logic s);
    int p, d, h, l, h2, expH, expL;
    p = periodOf(s);
    expH = (16 - int'(b[7:4])) * p;
    expL = (16 - int'(b[3:0])) * p;
    runEn = 1'b0; periodByte = b; tickSel = s;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    waitLevel(1'b1, d);
    checkRange("R5 first rise delay", d, 1, p);
    countLevel(1'b1, h);
    check("R1/R4 high length", h, expH);
    periodByte = ~b; tickSel = ~s;      // ignored while running (R6)
    countLevel(1'b0, l);
    check("R2/R6 low length", l, expL);
    check("R3 high follows low", int'(gateOut), 1);
    countLevel(1'b1, h2);
    check("R6 high length after write", h2, expH);
    runEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int d, h, l;
    runEn = 1'b1; periodByte = 8'hFF; tickSel = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 gate in reset", int'(gateOut), 0);
    check("R9 rise in reset", int'(riseOut), 0);
    check("R9 fall in reset", int'(fallOut), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    // enable held through reset: stored byte 0, select 0 -> 16 fast ticks
    waitLevel(1'b1, d);
    checkRange("R9 first rise delay", d, 1, periodOf(1'b0));
    countLevel(1'b1, h);
    check("R9 reset byte high length", h, 16 * periodOf(1'b0));
    countLevel(1'b0, l);
    check("R9 reset byte low length", l, 16 * periodOf(1'b0));
    runEn = 1'b0;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R7 idle gate", int'(gateOut), 0);

    // Exhaustive sweep on the fast tap
    for (int hi = 0; hi < 16; hi++)
      for (int lo = 0; lo < 16; lo++)
        runOne({hi[3:0], lo[3:0]}, 1'b0);
    // Slow tap sweep
    for (int n = 0; n < 16; n++)
      runOne({n[3:0], 4'(15 - n)}, 1'b1);

    // R7: stop mid-high, then re-enable gives full high interval
    runEn = 1'b0; periodByte = 8'h9C; tickSel = 1'b0;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    waitLevel(1'b1, d);
    repeat (3) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check("R7 gate low after stop", int'(gateOut), 0);
    check("R7 fall pulse on stop", int'(fallOut), 1);
    @(negedge clk);
    runEn = 1'b1;
    waitLevel(1'b1, d);
    checkRange("R7 restart delay", d, 1, periodOf(1'b0));
    countLevel(1'b1, h);
    check("R7 full high after restart", h, 7 * periodOf(1'b0));
    // stop during low, restart begins high
    repeat (2) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check("R7 no fall pulse when stopped in low", int'(fallOut), 0);
    runEn = 1'b1;
    waitLevel(1'b1, d);
    checkRange("R7 restart from low delay", d, 1, periodOf(1'b0));
    countLevel(1'b1, h);
    check("R7 restart from low high length", h, 7 * periodOf(1'b0));
    runEn = 1'b0;
    repeat (3) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule